// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block chooses where each ALU operand of a five-stage pipeline comes from. The instruction in the execute stage names two source registers. The block compares each of them against the destination registers still waiting in the two later pipeline registers: execute-to-memory and memory-to-writeback. When the register file value is stale, the block steers the newer result into the operand instead. It outputs a two-bit mux select for each operand and the operand value that select picks.

A second path serves the memory stage. A store whose data register was loaded by the instruction just ahead of it cannot get that value in the execute stage, because the load has not yet finished. This bypass substitutes the memory-to-writeback result for the store data while the store is in the memory stage.

The logic is purely combinational and holds no state. Stall generation and the register file are handled elsewhere. A write and a read of the same register in the same cycle are resolved inside the register file (write first, then read), not here.

Top module: `fwd_unit`

## Requirements
- R1: A source register that equals the execute-to-memory destination, with that stage's write enable and valid bit both set, gets select 2'b01, and its operand is the execute-to-memory ALU result.
- R2: A source register that equals the memory-to-writeback destination, with that stage's write enable and valid bit both set, gets select 2'b10. Its operand is the loaded data when the memory-to-register flag is 1, and the ALU result when the flag is 0.
- R3: When both later stages qualify for the same source register, the nearer execute-to-memory stage wins (select 2'b01).
- R4: Source register 0 never forwards. Its select is 2'b00 and its operand is the register file value, whatever the later stages hold.
- R5: A stage whose valid bit or write enable is 0 never supplies a forwarded value. An older qualifying stage may still forward in its place.
- R6: With no qualifying match, the select is 2'b00 and the operand is the register file value. The code 2'b11 is never produced.
- R7: The two operands are resolved independently, so one cycle can carry different selects for the first and second operand.
- R8: When the memory-stage store flag is 1, the store data register is nonzero, and it equals a memory-to-writeback destination whose write enable and valid bit are set, the store bypass flag is 1 and the store data is the memory-to-writeback result. Otherwise the flag is 0 and the store data is the carried value. The execute-to-memory stage never drives this path.
- R9: The outputs follow the inputs with no clock edge in between; the block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_idx | input | REG_W | First source register of the execute-stage instruction |
| ex_rt_idx | input | REG_W | Second source register of the execute-stage instruction |
| ex_rs_rf | input | DATA_W | Register file value read for the first source |
| ex_rt_rf | input | DATA_W | Register file value read for the second source |
| xm_dst | input | REG_W | Destination register held in the execute-to-memory stage |
| xm_wen | input | 1 | Register write enable of the execute-to-memory stage |
| xm_vld | input | 1 | Valid bit of the execute-to-memory stage |
| xm_alu | input | DATA_W | ALU result held in the execute-to-memory stage |
| mw_dst | input | REG_W | Destination register held in the memory-to-writeback stage |
| mw_wen | input | 1 | Register write enable of the memory-to-writeback stage |
| mw_vld | input | 1 | Valid bit of the memory-to-writeback stage |
| mw_to_reg | input | 1 | 1: the stage writes back loaded data; 0: it writes back the ALU result |
| mw_load | input | DATA_W | Loaded data held in the memory-to-writeback stage |
| mw_alu | input | DATA_W | ALU result held in the memory-to-writeback stage |
| mem_store | input | 1 | The memory-stage instruction is a valid store |
| mem_st_idx | input | REG_W | Store data register of the memory-stage instruction |
| mem_st_val | input | DATA_W | Store data carried down the pipeline |
| fwd_a_sel | output | 2 | First operand select: 00 register file, 01 execute-to-memory, 10 memory-to-writeback |
| fwd_b_sel | output | 2 | Second operand select, same encoding |
| opnd_a | output | DATA_W | First ALU operand after forwarding |
| opnd_b | output | DATA_W | Second ALU operand after forwarding |
| st_byp | output | 1 | The store data is taken from the memory-to-writeback result |
| st_data | output | DATA_W | Store data after the bypass |

## Verification
A vector table sets the two source registers against the two pending destinations. It covers single matches in either stage, a double match, a match on register zero, matches whose valid bit or write enable is cleared, and operands that resolve differently. Comparing the select with the operand tells apart a wrong priority from a wrong data leg, and the memory-to-register flag shows whether the older stage returns loaded data or the ALU result. Directed store cases check that the bypass fires only for a valid store against a valid, writing, nonzero older destination, and never from the nearer stage. A check taken with no clock edge after the inputs change confirms that the outputs follow the inputs directly.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source select codes (decoded by the operand muxes in the ALU path)
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_XM  = 2'b01,
    SRC_MW  = 2'b10
  } opnd_src_e;

endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src_idx,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [REG_W-1:0]  xm_dst,
  input  logic              xm_wen,
  input  logic              xm_vld,
  input  logic [DATA_W-1:0] xm_alu,
  input  logic [REG_W-1:0]  mw_dst,
  input  logic              mw_wen,
  input  logic              mw_vld,
  input  logic              mw_to_reg,
  input  logic [DATA_W-1:0] mw_load,
  input  logic [DATA_W-1:0] mw_alu,
  output opnd_src_e         sel,
  output logic [DATA_W-1:0] opnd
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic              src_live;
  logic              xm_hit;
  logic              mw_hit;
  logic [DATA_W-1:0] mw_res;

  // Compare, prioritise and mux in one process so every value seen by the
  // checks below comes from the same set of inputs.
  always_comb begin
    src_live = (src_idx != ZERO_REG);
    xm_hit   = src_live && xm_vld && xm_wen && (xm_dst == src_idx);
    mw_hit   = src_live && mw_vld && mw_wen && (mw_dst == src_idx);
    mw_res   = mw_to_reg ? mw_load : mw_alu;

    if (xm_hit) begin
      sel = SRC_XM;
    end else if (mw_hit) begin
      sel = SRC_MW;
    end else begin
      sel = SRC_RF;
    end

    case (sel)
      SRC_XM:  opnd = xm_alu;
      SRC_MW:  opnd = mw_res;
      default: opnd = rf_val;
    endcase

    AST_XM_SEL_QUAL: assert ((sel != SRC_XM) || (xm_vld && xm_wen && (xm_dst == src_idx)))
      else $error("execute-to-memory select without a qualifying writer"); // R1
    AST_MW_DATA: assert ((sel != SRC_MW) || (opnd == (mw_to_reg ? mw_load : mw_alu)))
      else $error("memory-to-writeback operand carries the wrong leg"); // R2
    AST_NEAREST_WINS: assert (!(xm_vld && xm_wen && (xm_dst == src_idx) && (src_idx != ZERO_REG))
                              || (sel == SRC_XM))
      else $error("older stage chosen over nearer writer"); // R3
    AST_NO_ZERO_FWD: assert ((src_idx != ZERO_REG) || ((sel == SRC_RF) && (opnd == rf_val)))
      else $error("register zero forwarded"); // R4
    AST_MW_SEL_QUAL: assert ((sel != SRC_MW) || (mw_vld && mw_wen && (mw_dst == src_idx)))
      else $error("memory-to-writeback select from a non-writing stage"); // R5
    AST_SEL_LEGAL: assert (sel != 2'b11)
      else $error("illegal select code"); // R6
  end

endmodule

// File: rtl/st_bypass.sv
module st_bypass #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              mem_store,
  input  logic [REG_W-1:0]  st_idx,
  input  logic [DATA_W-1:0] st_val,
  input  logic [REG_W-1:0]  mw_dst,
  input  logic              mw_wen,
  input  logic              mw_vld,
  input  logic              mw_to_reg,
  input  logic [DATA_W-1:0] mw_load,
  input  logic [DATA_W-1:0] mw_alu,
  output logic              byp,
  output logic [DATA_W-1:0] data
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [DATA_W-1:0] mw_res;

  always_comb begin
    mw_res = mw_to_reg ? mw_load : mw_alu;
    byp    = mem_store && (st_idx != ZERO_REG) && mw_vld && mw_wen && (mw_dst == st_idx);
    data   = byp ? mw_res : st_val;

    AST_ST_BYP_QUAL: assert (!byp || (mem_store && mw_vld && mw_wen && (st_idx != ZERO_REG)))
      else $error("store bypass without a qualifying writer"); // R8
    AST_ST_PASS: assert (byp || (data == st_val))
      else $error("store data altered without a bypass"); // R8
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  ex_rs_idx,
  input  logic [REG_W-1:0]  ex_rt_idx,
  input  logic [DATA_W-1:0] ex_rs_rf,
  input  logic [DATA_W-1:0] ex_rt_rf,
  input  logic [REG_W-1:0]  xm_dst,
  input  logic              xm_wen,
  input  logic              xm_vld,
  input  logic [DATA_W-1:0] xm_alu,
  input  logic [REG_W-1:0]  mw_dst,
  input  logic              mw_wen,
  input  logic              mw_vld,
  input  logic              mw_to_reg,
  input  logic [DATA_W-1:0] mw_load,
  input  logic [DATA_W-1:0] mw_alu,
  input  logic              mem_store,
  input  logic [REG_W-1:0]  mem_st_idx,
  input  logic [DATA_W-1:0] mem_st_val,
  output logic [1:0]        fwd_a_sel,
  output logic [1:0]        fwd_b_sel,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              st_byp,
  output logic [DATA_W-1:0] st_data
);

  localparam int NUM_OPND = 2;

  logic [REG_W-1:0]  src_idx [NUM_OPND];
  logic [DATA_W-1:0] rf_val  [NUM_OPND];
  opnd_src_e         sel     [NUM_OPND];
  logic [DATA_W-1:0] opnd    [NUM_OPND];

  assign src_idx[0] = ex_rs_idx;
  assign src_idx[1] = ex_rt_idx;
  assign rf_val[0]  = ex_rs_rf;
  assign rf_val[1]  = ex_rt_rf;

  // One independent selector per ALU operand (R7)
  generate
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
      fwd_pick #(
        .REG_W  (REG_W),
        .DATA_W (DATA_W)
      ) u_pick (
        .src_idx   (src_idx[g]),
        .rf_val    (rf_val[g]),
        .xm_dst    (xm_dst),
        .xm_wen    (xm_wen),
        .xm_vld    (xm_vld),
        .xm_alu    (xm_alu),
        .mw_dst    (mw_dst),
        .mw_wen    (mw_wen),
        .mw_vld    (mw_vld),
        .mw_to_reg (mw_to_reg),
        .mw_load   (mw_load),
        .mw_alu    (mw_alu),
        .sel       (sel[g]),
        .opnd      (opnd[g])
      );
    end
  endgenerate

  assign fwd_a_sel = sel[0];
  assign fwd_b_sel = sel[1];
  assign opnd_a    = opnd[0];
  assign opnd_b    = opnd[1];

  st_bypass #(
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
  ) u_st_byp (
    .mem_store (mem_store),
    .st_idx    (mem_st_idx),
    .st_val    (mem_st_val),
    .mw_dst    (mw_dst),
    .mw_wen    (mw_wen),
    .mw_vld    (mw_vld),
    .mw_to_reg (mw_to_reg),
    .mw_load   (mw_load),
    .mw_alu    (mw_alu),
    .byp       (st_byp),
    .data      (st_data)
  );

endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;

  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  localparam logic [DATA_W-1:0] RF_A = 32'hA0A0_0001;
  localparam logic [DATA_W-1:0] RF_B = 32'hB0B0_0002;
  localparam logic [DATA_W-1:0] XM_V = 32'h1111_1111;
  localparam logic [DATA_W-1:0] MA_V = 32'h2222_2222;
  localparam logic [DATA_W-1:0] ML_V = 32'h3333_3333;
  localparam logic [DATA_W-1:0] ST_V = 32'h5A5A_5A5A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [REG_W-1:0]  ex_rs_idx, ex_rt_idx, xm_dst, mw_dst, mem_st_idx;
  logic [DATA_W-1:0] ex_rs_rf, ex_rt_rf, xm_alu, mw_load, mw_alu, mem_st_val;
  logic              xm_wen, xm_vld, mw_wen, mw_vld, mw_to_reg, mem_store;
  logic [1:0]        fwd_a_sel, fwd_b_sel;
  logic [DATA_W-1:0] opnd_a, opnd_b, st_data;
  logic              st_byp;

  fwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) dut (
    .ex_rs_idx (ex_rs_idx), .ex_rt_idx (ex_rt_idx),
    .ex_rs_rf  (ex_rs_rf),  .ex_rt_rf  (ex_rt_rf),
    .xm_dst    (xm_dst),    .xm_wen    (xm_wen),
    .xm_vld    (xm_vld),    .xm_alu    (xm_alu),
    .mw_dst    (mw_dst),    .mw_wen    (mw_wen),
    .mw_vld    (mw_vld),    .mw_to_reg (mw_to_reg),
    .mw_load   (mw_load),   .mw_alu    (mw_alu),
    .mem_store (mem_store), .mem_st_idx(mem_st_idx),
    .mem_st_val(mem_st_val),
    .fwd_a_sel (fwd_a_sel), .fwd_b_sel (fwd_b_sel),
    .opnd_a    (opnd_a),    .opnd_b    (opnd_b),
    .st_byp    (st_byp),    .st_data   (st_data)
  );

  typedef struct packed {
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] xd;
    logic             xw;
    logic             xv;
    logic [REG_W-1:0] md;
    logic             mwe;
    logic             mv;
    logic             m2r;
    logic [1:0]       ea;
    logic [1:0]       eb;
    logic [3:0]       req;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{5'd3,  5'd4,  5'd7,  1'b1, 1'b1, 5'd8,  1'b1, 1'b1, 1'b0, 2'b00, 2'b00, 4'd6}, // R6 no match
    '{5'd7,  5'd4,  5'd7,  1'b1, 1'b1, 5'd8,  1'b1, 1'b1, 1'b0, 2'b01, 2'b00, 4'd1}, // R1
    '{5'd3,  5'd8,  5'd7,  1'b1, 1'b1, 5'd8,  1'b1, 1'b1, 1'b1, 2'b00, 2'b10, 4'd2}, // R2 loaded data
    '{5'd8,  5'd8,  5'd7,  1'b1, 1'b1, 5'd8,  1'b1, 1'b1, 1'b0, 2'b10, 2'b10, 4'd2}, // R2 ALU result
    '{5'd9,  5'd9,  5'd9,  1'b1, 1'b1, 5'd9,  1'b1, 1'b1, 1'b1, 2'b01, 2'b01, 4'd3}, // R3
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b1, 1'b1, 2'b00, 2'b00, 4'd4}, // R4
    '{5'd5,  5'd6,  5'd5,  1'b0, 1'b1, 5'd6,  1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 4'd5}, // R5
    '{5'd5,  5'd5,  5'd5,  1'b1, 1'b0, 5'd5,  1'b1, 1'b1, 1'b1, 2'b10, 2'b10, 4'd5}, // R5 invalid nearest
    '{5'd5,  5'd6,  5'd5,  1'b0, 1'b1, 5'd6,  1'b1, 1'b1, 1'b0, 2'b00, 2'b10, 4'd7}, // R7
    '{5'd31, 5'd1,  5'd31, 1'b1, 1'b1, 5'd1,  1'b1, 1'b1, 1'b1, 2'b01, 2'b10, 4'd7}, // R7
    '{5'd12, 5'd12, 5'd12, 1'b0, 1'b0, 5'd12, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'd5}  // R5
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_opnd(input logic [1:0] s,
      input logic [DATA_W-1:0] rf, input logic m2r);
    case (s)
      2'b01:   return XM_V;
      2'b10:   return m2r ? ML_V : MA_V;
      default: return rf;
    endcase
  endfunction

  task automatic apply(input vec_t v);
    ex_rs_idx = v.rs;  ex_rt_idx = v.rt;
    xm_dst = v.xd;     xm_wen = v.xw;   xm_vld = v.xv;
    mw_dst = v.md;     mw_wen = v.mwe;  mw_vld = v.mv;  mw_to_reg = v.m2r;
  endtask

  initial begin
    ex_rs_idx = '0; ex_rt_idx = '0; xm_dst = '0; mw_dst = '0; mem_st_idx = '0;
    ex_rs_rf = RF_A; ex_rt_rf = RF_B; xm_alu = XM_V; mw_load = ML_V; mw_alu = MA_V;
    mem_st_val = ST_V;
    xm_wen = 1'b0; xm_vld = 1'b0; mw_wen = 1'b0; mw_vld = 1'b0; mw_to_reg = 1'b0;
    mem_store = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Quiescent state: nothing pending, nothing forwarded (R6, R8)
    chk("R6 idle sel a", {30'd0, fwd_a_sel}, 32'd0);
    chk("R6 idle sel b", {30'd0, fwd_b_sel}, 32'd0);
    chk("R6 idle opnd a", opnd_a, RF_A);
    chk("R8 idle st_byp", {31'd0, st_byp}, 32'd0);
    chk("R8 idle st_data", st_data, ST_V);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      #1;
      chk($sformatf("R%0d vec%0d sel a", VECS[i].req, i), {30'd0, fwd_a_sel}, {30'd0, VECS[i].ea});
      chk($sformatf("R%0d vec%0d sel b", VECS[i].req, i), {30'd0, fwd_b_sel}, {30'd0, VECS[i].eb});
      chk($sformatf("R%0d vec%0d opnd a", VECS[i].req, i), opnd_a,
          exp_opnd(VECS[i].ea, RF_A, VECS[i].m2r));
      chk($sformatf("R%0d vec%0d opnd b", VECS[i].req, i), opnd_b,
          exp_opnd(VECS[i].eb, RF_B, VECS[i].m2r));
    end

    // R9: outputs move within the low half-period, no rising edge in between
    @(negedge clk);
    apply(VECS[0]);
    #1;
    chk("R9 before change", {30'd0, fwd_a_sel}, 32'd0);
    apply(VECS[1]);
    #1;
    chk("R9 sel follows input", {30'd0, fwd_a_sel}, 32'd1);
    chk("R9 opnd follows input", opnd_a, XM_V);

    // Store bypass cases (R8)
    @(negedge clk);
    ex_rs_idx = 5'd2; ex_rt_idx = 5'd3;
    xm_dst = 5'd20; xm_wen = 1'b1; xm_vld = 1'b1;
    mw_dst = 5'd6; mw_wen = 1'b1; mw_vld = 1'b1; mw_to_reg = 1'b1;
    mem_store = 1'b1; mem_st_idx = 5'd6;
    #1;
    chk("R8 load then store byp", {31'd0, st_byp}, 32'd1);
    chk("R8 load then store data", st_data, ML_V);
    mw_to_reg = 1'b0;
    #1;
    chk("R8 ALU result data", st_data, MA_V);
    mem_store = 1'b0;
    #1;
    chk("R8 not a store byp", {31'd0, st_byp}, 32'd0);
    chk("R8 not a store data", st_data, ST_V);
    mem_store = 1'b1; mw_vld = 1'b0;
    #1;
    chk("R8 invalid writer", st_data, ST_V);
    mw_vld = 1'b1; mw_wen = 1'b0;
    #1;
    chk("R8 non-writing stage", st_data, ST_V);
    mw_wen = 1'b1; mw_dst = 5'd0; mem_st_idx = 5'd0;
    #1;
    chk("R8 register zero", {31'd0, st_byp}, 32'd0);
    mw_dst = 5'd9; mem_st_idx = 5'd20;
    #1;
    chk("R8 nearer stage ignored byp", {31'd0, st_byp}, 32'd0);
    chk("R8 nearer stage ignored data", st_data, ST_V);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule